// File: doc/BRIEF.md
# Frame Word to Pixel Bus Formatter

This block sits between a frame-buffer word FIFO and the parallel data pins of a display. Each 32-bit word arrives on a valid/ready input and is held in a one-word register. The block then sends one or more pixel beats on a 24-bit output bus, also with valid/ready handshaking. Three static configuration inputs set the behaviour: a pixel-size code, a bus-width code and a per-byte valid mask. Together they decide how many pixels each word holds, which bytes take part, and how the colour channels are placed on the bus.

Two pixel sizes are supported. Packed 5-6-5 pixels come two per word. 8-8-8 pixels come one per word, and the top byte of the word is unused. The bus can be 24, 18, 16 or 8 bits wide; unused high lines are driven low. Pairing 8-8-8 pixels with the 8-bit bus is rejected, as are the unsupported size codes. In those cases an error flag rises and both handshakes stall. A clear input discards the held word so that the block can be reconfigured from a clean state.

Top module: `pix_word_formatter`

## Requirements
- R1: With `cfgWordLen` = 0, each word carries two 5-6-5 pixels (red in bits 15:11, green in 10:5, blue in 4:0 of a halfword). The halfword in bits 15:0 is sent before the one in bits 31:16.
- R2: With `cfgWordLen` = 3, each word carries one pixel: red in bits 23:16, green in 15:8, blue in 7:0. Bits 31:24 have no effect on the output.
- R3: `cfgByteMask` bit i marks byte i of the word as holding data. In 5-6-5 mode, a halfword is sent only when both of its byte bits are set. A word with no complete halfword is consumed and produces no beat. In 8-8-8 mode, a byte whose bit is clear is read as zero.
- R4: When `cfgBusWidth` = 3 (24-bit bus), `outData` is {R8,G8,B8}. A 5-6-5 channel is left-aligned in its 8 bits, and its top bits are copied into the low bits (red and blue: the 3 MSBs; green: the 2 MSBs).
- R5: When `cfgBusWidth` = 2 (18-bit bus), `outData[17:0]` is {R6,G6,B6}. An 8-bit channel keeps its 6 MSBs. A 5-bit channel becomes 6 bits by copying its MSB into the new LSB. Bits 23:18 are zero.
- R6: When `cfgBusWidth` = 0 (16-bit bus), `outData[15:0]` is the 5-6-5 halfword unchanged, or for 8-8-8 pixels {R[7:3],G[7:2],B[7:3]}. Bits 23:16 are zero.
- R7: When `cfgBusWidth` = 1 (8-bit bus) and 5-6-5 pixels are selected, each pixel is sent as two beats on `outData[7:0]`: bits 7:0 of the halfword first, then bits 15:8. Bits 23:8 are zero.
- R8: `cfgError` is high in the same cycle whenever `cfgWordLen` is 1 or 2, or when `cfgWordLen` = 3 together with `cfgBusWidth` = 1. While it is high, `inReady` and `outValid` are low. A held word is kept and resumes once the configuration is valid again.
- R9: While `fifoClear` is high, `inReady` and `outValid` are low and the held word is discarded. After clear drops, `outValid` stays low until a new word is accepted.
- R10: While `outValid` is high and `outReady` is low, `outData` and `outValid` hold. `inReady` is high when the register is empty, or when the final beat of the held word is being taken in that cycle, so words can follow each other with no gap.
- R11: After reset, with a valid configuration, `outValid` is low and `inReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWordLen | input | 2 | Pixel size code: 0 = 5-6-5 pairs, 3 = 8-8-8 single |
| cfgBusWidth | input | 2 | Bus code: 0 = 16, 1 = 8, 2 = 18, 3 = 24 bits |
| cfgByteMask | input | 4 | Per-byte data-valid mask for each word |
| fifoClear | input | 1 | Discard the held word |
| inValid | input | 1 | Input word valid |
| inData | input | 32 | Input frame-buffer word |
| inReady | output | 1 | Block can take a word |
| outValid | output | 1 | Pixel beat valid |
| outData | output | 24 | Pixel beat |
| outReady | input | 1 | Display side takes the beat |
| cfgError | output | 1 | Invalid configuration flag |

## Verification
The assertions check the cycle-level rules on every cycle: both handshakes are stalled while the configuration is invalid or a clear is active, the output stays empty after a clear, a stalled beat holds its data, the error flag covers the rejected size and bus pairing, and unused bus lines are zero. The bus scenarios show the channel placement, the bit replication and truncation, the halfword and byte ordering, the effect of the byte mask, and a word being dropped when its mask leaves no complete pixel. Those scenarios compare the beats with values the bench computes itself. The bench also shows back-to-back word transfer and that a held word survives a period of invalid configuration.

// File: rtl/pixfmt_pkg.sv
package pixfmt_pkg;
  localparam int WORD_W    = 32;
  localparam int HALF_W    = WORD_W / 2;
  localparam int MASK_W    = WORD_W / 8;
  localparam int PIX_BYTES = 3;
  localparam int BUS_W     = 24;

  localparam logic [1:0] WL_16 = 2'd0;
  localparam logic [1:0] WL_32 = 2'd3;

  localparam logic [1:0] BW_16 = 2'd0;
  localparam logic [1:0] BW_8  = 2'd1;
  localparam logic [1:0] BW_18 = 2'd2;
  localparam logic [1:0] BW_24 = 2'd3;

  typedef struct packed {
    logic loadWord;
    logic selHigh;
    logic selByteHi;
  } fmtStrobe_t;
endpackage

// File: rtl/pixfmt_ctrl.sv
module pixfmt_ctrl
  import pixfmt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        wordLen,
  input  logic [1:0]        busWidth,
  input  logic [MASK_W-1:0] byteMask,
  input  logic              fifoClear,
  input  logic              inValid,
  input  logic              outReady,
  output logic              inReady,
  output logic              outValid,
  output logic              badCfg,
  output fmtStrobe_t        strobe
);
  logic full, hwHigh, byteHigh;
  logic mode16, mode32, bus8, lowOk, highOk, lastBeat, take, accept;

  always_comb begin
    mode16   = (wordLen == WL_16);
    mode32   = (wordLen == WL_32);
    bus8     = (busWidth == BW_8);
    badCfg   = !(mode16 || mode32) || (mode32 && bus8);
    lowOk    = &byteMask[1:0];
    highOk   = &byteMask[3:2];
    lastBeat = mode32 || ((!bus8 || byteHigh) && (hwHigh || !highOk));
    outValid = full && !badCfg && !fifoClear;
    take     = outValid && outReady;
    inReady  = !badCfg && !fifoClear && (!full || (take && lastBeat));
    accept   = inValid && inReady;
    strobe.loadWord  = accept;
    strobe.selHigh   = hwHigh;
    strobe.selByteHi = byteHigh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      full     <= 1'b0;
      hwHigh   <= 1'b0;
      byteHigh <= 1'b0;
    end else if (fifoClear) begin
      full     <= 1'b0;
      hwHigh   <= 1'b0;
      byteHigh <= 1'b0;
    end else if (accept) begin
      full     <= mode32 || lowOk || highOk;
      hwHigh   <= mode16 && !lowOk;
      byteHigh <= 1'b0;
    end else if (take) begin
      if (lastBeat) begin
        full     <= 1'b0;
        hwHigh   <= 1'b0;
        byteHigh <= 1'b0;
      end else if (bus8 && !byteHigh) begin
        byteHigh <= 1'b1;
      end else begin
        byteHigh <= 1'b0;
        hwHigh   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pixfmt_datapath.sv
module pixfmt_datapath
  import pixfmt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           wordLen,
  input  logic [1:0]           busWidth,
  input  logic [PIX_BYTES-1:0] byteMask,
  input  logic [WORD_W-1:0]    inData,
  input  fmtStrobe_t           strobe,
  output logic [BUS_W-1:0]     outData
);
  logic [WORD_W-1:0]      wordQ;
  logic [PIX_BYTES*8-1:0] maskedW;
  logic [HALF_W-1:0]      half;
  logic [4:0] r5, b5;
  logic [5:0] g6;
  logic [7:0] r8, g8, b8;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wordQ <= '0;
    else if (strobe.loadWord) wordQ <= inData;
  end

  for (genvar i = 0; i < PIX_BYTES; i++) begin : gByte
    assign maskedW[i*8 +: 8] = byteMask[i] ? wordQ[i*8 +: 8] : 8'h00;
  end

  always_comb begin
    half = strobe.selHigh ? wordQ[WORD_W-1:HALF_W] : wordQ[HALF_W-1:0];
    r5 = half[15:11];
    g6 = half[10:5];
    b5 = half[4:0];
    r8 = maskedW[23:16];
    g8 = maskedW[15:8];
    b8 = maskedW[7:0];
    outData = '0;
    if (wordLen == WL_32) begin
      case (busWidth)
        BW_24:   outData = {r8, g8, b8};
        BW_18:   outData[17:0] = {r8[7:2], g8[7:2], b8[7:2]};
        BW_16:   outData[15:0] = {r8[7:3], g8[7:2], b8[7:3]};
        default: outData = '0;
      endcase
    end else begin
      case (busWidth)
        BW_24:   outData = {r5, r5[4:2], g6, g6[5:4], b5, b5[4:2]};
        BW_18:   outData[17:0] = {r5, r5[4], g6, b5, b5[4]};
        BW_16:   outData[15:0] = half;
        default: outData[7:0] = strobe.selByteHi ? half[15:8] : half[7:0];
      endcase
    end
  end
endmodule

// File: rtl/pix_word_formatter.sv
module pix_word_formatter
  import pixfmt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cfgWordLen,
  input  logic [1:0]        cfgBusWidth,
  input  logic [MASK_W-1:0] cfgByteMask,
  input  logic              fifoClear,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inData,
  output logic              inReady,
  output logic              outValid,
  output logic [BUS_W-1:0]  outData,
  input  logic              outReady,
  output logic              cfgError
);
  fmtStrobe_t strobe;

  pixfmt_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .wordLen(cfgWordLen), .busWidth(cfgBusWidth),
    .byteMask(cfgByteMask), .fifoClear(fifoClear), .inValid(inValid),
    .outReady(outReady), .inReady(inReady), .outValid(outValid),
    .badCfg(cfgError), .strobe(strobe)
  );

  pixfmt_datapath uData (
    .clk(clk), .rstN(rstN), .wordLen(cfgWordLen), .busWidth(cfgBusWidth),
    .byteMask(cfgByteMask[PIX_BYTES-1:0]), .inData(inData), .strobe(strobe),
    .outData(outData)
  );
endmodule

// File: rtl/pixfmt_checker.sv
module pixfmt_checker
  import pixfmt_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        cfgWordLen,
  input logic [1:0]        cfgBusWidth,
  input logic [MASK_W-1:0] cfgByteMask,
  input logic              fifoClear,
  input logic              inReady,
  input logic              outValid,
  input logic [BUS_W-1:0]  outData,
  input logic              outReady,
  input logic              cfgError
);
  a_r8_error_stalls: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> (!outValid && !inReady));

  a_r8_bad_pairing: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWordLen == WL_32 && cfgBusWidth == BW_8) |-> cfgError);

  a_r9_clear_stalls: assert property (@(posedge clk) disable iff (!rstN)
    fifoClear |-> (!outValid && !inReady));

  a_r9_empty_after_clear: assert property (@(posedge clk) disable iff (!rstN)
    fifoClear |=> !outValid);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=>
      (fifoClear || cfgError || !$stable(cfgWordLen) || !$stable(cfgBusWidth) ||
       !$stable(cfgByteMask) || (outValid && $stable(outData))));

  a_r5_bus18_high_zero: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && cfgBusWidth == BW_18) |-> (outData[23:18] == '0));

  a_r6_bus16_high_zero: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && cfgBusWidth == BW_16) |-> (outData[23:16] == '0));

  a_r7_bus8_high_zero: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && cfgBusWidth == BW_8) |-> (outData[23:8] == '0));
endmodule

bind pix_word_formatter pixfmt_checker uChk (
  .clk(clk), .rstN(rstN), .cfgWordLen(cfgWordLen), .cfgBusWidth(cfgBusWidth),
  .cfgByteMask(cfgByteMask), .fifoClear(fifoClear), .inReady(inReady),
  .outValid(outValid), .outData(outData), .outReady(outReady), .cfgError(cfgError)
);

// File: tb/tb_pix_word_formatter.sv
module tb_pix_word_formatter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] cfgWordLen = 2'd0;
  logic [1:0] cfgBusWidth = 2'd3;
  logic [3:0] cfgByteMask = 4'hF;
  logic fifoClear = 1'b0;
  logic inValid = 1'b0;
  logic [31:0] inData = '0;
  logic inReady, outValid, outReady, cfgError;
  logic [23:0] outData;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  initial outReady = 1'b0;
  always #10 clk = ~clk;

  pix_word_formatter dut (
    .clk(clk), .rstN(rstN), .cfgWordLen(cfgWordLen), .cfgBusWidth(cfgBusWidth),
    .cfgByteMask(cfgByteMask), .fifoClear(fifoClear), .inValid(inValid),
    .inData(inData), .inReady(inReady), .outValid(outValid), .outData(outData),
    .outReady(outReady), .cfgError(cfgError)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] fmt16(input logic [15:0] hw, input logic [1:0] bw);
    logic [4:0] r; logic [5:0] g; logic [4:0] b;
    r = hw[15:11]; g = hw[10:5]; b = hw[4:0];
    case (bw)
      2'd3: return {r, r[4:2], g, g[5:4], b, b[4:2]};
      2'd2: return {6'd0, r, r[4], g, b, b[4]};
      2'd0: return {8'd0, hw};
      default: return 24'd0;
    endcase
  endfunction

  function automatic logic [23:0] fmt32(input logic [31:0] w, input logic [3:0] m, input logic [1:0] bw);
    logic [7:0] r, g, b;
    r = m[2] ? w[23:16] : 8'd0;
    g = m[1] ? w[15:8] : 8'd0;
    b = m[0] ? w[7:0] : 8'd0;
    case (bw)
      2'd3: return {r, g, b};
      2'd2: return {6'd0, r[7:2], g[7:2], b[7:2]};
      2'd0: return {8'd0, r[7:3], g[7:2], b[7:3]};
      default: return 24'd0;
    endcase
  endfunction

  task automatic setCfg(input logic [1:0] wl, input logic [1:0] bw, input logic [3:0] m);
    cfgWordLen = wl; cfgBusWidth = bw; cfgByteMask = m;
    #1;
  endtask

  task automatic pushWord(input logic [31:0] w);
    inData = w; inValid = 1'b1;
    for (int i = 0; i < 20 && !inReady; i++) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic expectPix(input logic [23:0] exp, input string req);
    for (int i = 0; i < 20 && !outValid; i++) @(negedge clk);
    check(outValid && outData == exp, req, {7'd0, outValid, outData}, {8'h01, exp});
    outReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    outReady = 1'b0;
  endtask

  task automatic expectEmpty(input string req);
    check(!outValid, req, {31'd0, outValid}, 32'd0);
  endtask

  task automatic t_reset;
    check(!outValid && inReady && !cfgError, "R11 reset state",
          {29'd0, outValid, inReady, cfgError}, 32'b010);
  endtask

  task automatic t_bus24;
    setCfg(2'd0, 2'd3, 4'hF);
    pushWord(32'hF81F_07E0);
    expectPix(fmt16(16'h07E0, 2'd3), "R1 R4 low halfword first");
    expectPix(fmt16(16'hF81F, 2'd3), "R1 R4 high halfword second");
    pushWord(32'h1234_ABCD);
    expectPix(fmt16(16'hABCD, 2'd3), "R4 replicate low pix");
    expectPix(fmt16(16'h1234, 2'd3), "R4 replicate high pix");
    expectEmpty("R1 two beats per word");
    setCfg(2'd3, 2'd3, 4'hF);
    pushWord(32'hAA12_3456);
    expectPix(24'h123456, "R2 R4 888 on 24 bit bus");
    expectEmpty("R2 one beat per word");
  endtask

  task automatic t_bus18;
    setCfg(2'd3, 2'd2, 4'hF);
    pushWord(32'h00FC_8040);
    expectPix(fmt32(32'h00FC_8040, 4'hF, 2'd2), "R5 888 truncated to 6 bits");
    setCfg(2'd0, 2'd2, 4'hF);
    pushWord(32'h8421_F00F);
    expectPix(fmt16(16'hF00F, 2'd2), "R5 565 low pix on 18 bit");
    expectPix(fmt16(16'h8421, 2'd2), "R5 565 high pix on 18 bit");
  endtask

  task automatic t_bus16;
    setCfg(2'd0, 2'd0, 4'hF);
    pushWord(32'hBEEF_CAFE);
    expectPix(24'h00CAFE, "R6 565 raw low");
    expectPix(24'h00BEEF, "R6 565 raw high");
    setCfg(2'd3, 2'd0, 4'hF);
    pushWord(32'h55F8_FCF8);
    expectPix(fmt32(32'h55F8_FCF8, 4'hF, 2'd0), "R6 888 truncated to 565");
  endtask

  task automatic t_bus8;
    setCfg(2'd0, 2'd1, 4'hF);
    pushWord(32'hBEEF_1234);
    expectPix(24'h000034, "R7 beat0");
    expectPix(24'h000012, "R7 beat1");
    expectPix(24'h0000EF, "R7 beat2");
    expectPix(24'h0000BE, "R7 beat3");
    expectEmpty("R7 four beats per word");
  endtask

  task automatic t_mask;
    setCfg(2'd0, 2'd0, 4'hC);
    pushWord(32'h1111_2222);
    expectPix(24'h001111, "R3 only high halfword");
    expectEmpty("R3 low halfword skipped");
    setCfg(2'd0, 2'd0, 4'h3);
    pushWord(32'h3333_4444);
    expectPix(24'h004444, "R3 only low halfword");
    expectEmpty("R3 high halfword skipped");
    setCfg(2'd0, 2'd0, 4'h0);
    pushWord(32'hAAAA_BBBB);
    expectEmpty("R3 word with empty mask dropped");
    check(inReady, "R3 dropped word leaves block ready", {31'd0, inReady}, 32'd1);
    setCfg(2'd0, 2'd0, 4'hF);
    pushWord(32'h5555_6666);
    expectPix(24'h006666, "R3 next word follows drop");
    expectPix(24'h005555, "R3 next word high");
    setCfg(2'd3, 2'd3, 4'h5);
    pushWord(32'hFF11_2233);
    expectPix(24'h110033, "R3 888 masked byte reads zero");
  endtask

  task automatic t_error;
    setCfg(2'd1, 2'd3, 4'hF);
    check(cfgError && !inReady && !outValid, "R8 size code 1",
          {29'd0, cfgError, inReady, outValid}, 32'b100);
    setCfg(2'd2, 2'd0, 4'hF);
    check(cfgError && !inReady, "R8 size code 2", {30'd0, cfgError, inReady}, 32'b10);
    setCfg(2'd3, 2'd1, 4'hF);
    check(cfgError && !inReady, "R8 888 with 8 bit bus", {30'd0, cfgError, inReady}, 32'b10);
    setCfg(2'd0, 2'd1, 4'hF);
    check(!cfgError, "R8 565 with 8 bit bus allowed", {31'd0, cfgError}, 32'd0);
    pushWord(32'h0000_9876);
    setCfg(2'd3, 2'd1, 4'hF);
    @(negedge clk);
    check(!outValid && !inReady, "R8 held word stalls", {30'd0, outValid, inReady}, 32'd0);
    setCfg(2'd0, 2'd1, 4'hF);
    expectPix(24'h000076, "R8 held word resumes beat0");
    expectPix(24'h000098, "R8 held word resumes beat1");
    expectPix(24'h000000, "R8 held word resumes beat2");
    expectPix(24'h000000, "R8 held word resumes beat3");
  endtask

  task automatic t_clear;
    setCfg(2'd3, 2'd3, 4'hF);
    pushWord(32'h00AB_CDEF);
    fifoClear = 1'b1;
    #1;
    check(!outValid && !inReady, "R9 stall during clear", {30'd0, outValid, inReady}, 32'd0);
    @(negedge clk);
    fifoClear = 1'b0;
    #1;
    expectEmpty("R9 word discarded");
    @(negedge clk);
    expectEmpty("R9 stays empty");
    pushWord(32'h0001_0203);
    expectPix(24'h010203, "R9 new word after clear");
  endtask

  task automatic t_hold;
    logic [23:0] first;
    setCfg(2'd0, 2'd3, 4'hF);
    pushWord(32'h1234_5678);
    first = outData;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(outValid && outData == first, "R10 stalled beat holds", {7'd0, outValid, outData}, {8'h01, first});
    end
    check(!inReady, "R10 not ready mid word", {31'd0, inReady}, 32'd0);
    expectPix(fmt16(16'h5678, 2'd3), "R10 first beat after stall");
    outReady = 1'b1;
    #1;
    check(inReady, "R10 ready while last beat taken", {31'd0, inReady}, 32'd1);
    outReady = 1'b0;
    expectPix(fmt16(16'h1234, 2'd3), "R10 second beat");
    setCfg(2'd3, 2'd3, 4'hF);
    pushWord(32'h00A0_B0C0);
    outReady = 1'b1;
    inData = 32'h00D0_E0F0;
    inValid = 1'b1;
    #1;
    check(inReady, "R10 back to back ready", {31'd0, inReady}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    outReady = 1'b0;
    inValid = 1'b0;
    #1;
    check(outValid && outData == 24'hD0E0F0, "R10 back to back next word",
          {7'd0, outValid, outData}, 32'h01D0E0F0);
    expectPix(24'hD0E0F0, "R10 drain");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_bus24();
    t_bus18();
    t_bus16();
    t_bus8();
    t_mask();
    t_error();
    t_clear();
    t_hold();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule